// File: doc/BRIEF.md
# Camera Frame Capture Writer

This block sits in the pixel clock domain of a parallel image sensor and turns the sensor's raw stream into writes for a dual-clock frame buffer. The sensor provides an 8-bit pixel byte on every pixel clock tick, a vertical sync that is high between frames, and a line reference that is high while a line's pixels are on the bus. The block counts columns and rows from those two framing signals rather than trusting fixed constants. This lets it follow full 640x480 frames as well as shorter lines or fewer rows.

Writing is gated by the sensor-configuration done flag. After the flag rises, the block waits for a vertical sync pulse before it stores anything, so a frame already in progress is never written. With a decimation shift of S, only pixels whose column and row are both multiples of 2^S are written. They go to a packed buffer of (IMG_W>>S) x (IMG_H>>S) bytes at row-major addresses. Pixels outside the configured geometry are dropped. A one-cycle frame-complete pulse marks the end of every captured frame that carried at least one active line.

The write side is a valid-only stream: `wr_valid` qualifies `wr_addr` and `wr_data` for one cycle, and there is no ready input. The buffer's write port must accept one write on every pixel clock, because the sensor cannot be stalled. The display side reads the buffer on its own clock and is outside this block.

Top module: `cap_frame_writer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `wr_valid` and `frame_done` are 0.
- R2: While `cfg_done` is low, `wr_valid` stays 0 whatever the framing inputs do.
- R3: After `cfg_done` rises, no write is issued until `vsync` has been sampled high. Lines that arrive before that pulse are not stored.
- R4: A pixel is a candidate for writing only on a clock where `vsync` is 0 and `href` is 1. Bytes seen during blanking or during the vsync pulse are never written.
- R5: With decimation shift S and sensor column c and row r, a pixel is written only when c mod 2^S = 0 and r mod 2^S = 0. It is written to address (r>>S)*(IMG_W>>S) + (c>>S) with the sampled byte as data. `wr_valid`, `wr_addr` and `wr_data` appear one clock after the pixel is sampled.
- R6: The column index restarts at 0 on the first clock of every `href` high period. The row index is 0 while `vsync` is high and advances by one on each falling edge of `href`. Frames with shorter lines or fewer rows are therefore placed by their counted position.
- R7: Pixels with column ≥ IMG_W or row ≥ IMG_H are not written, and no address reaches (IMG_W>>S)*(IMG_H>>S).
- R8: `frame_done` is a one-cycle pulse, issued one clock after `vsync` is sampled rising. It is issued only if capture was running and at least one line ended with `vsync` low since the previous rising edge of `vsync`.
- R9: If `cfg_done` falls during a frame, writes stop on the next pixel. Capture then resumes only after `cfg_done` is high again and a new `vsync` pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Sensor pixel clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Sensor configuration finished; capture is allowed while high |
| vsync | input | 1 | Vertical sync from the sensor, high between frames |
| href | input | 1 | Line reference, high while pixel bytes are valid |
| pix_data | input | 8 | Pixel byte from the sensor |
| wr_valid | output | 1 | Write strobe for the frame buffer (no back-pressure) |
| wr_addr | output | ADDR_W | Buffer address of the written pixel |
| wr_data | output | 8 | Pixel byte to store |
| frame_done | output | 1 | One-cycle pulse at the end of a captured frame |

## Verification
The bench builds the block with IMG_W=8, IMG_H=6 and DEC_SHIFT=1, so one full frame is only 48 pixels and fills a 12-entry buffer. At that size every pixel of every frame can be checked individually against the arithmetic address rule. Because the frame is small, the bench can also afford many kinds of frame: full frames, short lines with fewer rows, and overlong lines with extra rows that must be clipped. It also covers a frame already running when the done flag rises, a done flag that drops mid-frame, and vsync pulses that enclose no active line. The frame-complete pulse is predicted on every rising edge of vsync.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_RUN  = 2'd2
  } arm_state_e;
endpackage

// File: rtl/cap_geom.sv
module cap_geom #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int COL_W = $clog2(IMG_W + 1),
  localparam int ROW_W = $clog2(IMG_H + 1)
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             href,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row,
  output logic             pix_ok,
  output logic             line_end,
  output logic             vs_rise
);
  logic             hr_prev, vs_prev;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             hr_rise;

  assign hr_rise  = href & ~hr_prev;
  assign line_end = hr_prev & ~href;
  assign vs_rise  = vsync & ~vs_prev;
  assign pix_ok   = href & ~vsync;
  assign pix_col  = hr_rise ? '0 : col_q;
  assign pix_row  = row_q;

  always_ff @(posedge clk_pix) begin
    if (!rst_n) begin
      hr_prev <= 1'b0;
      vs_prev <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
    end else begin
      hr_prev <= href;
      vs_prev <= vsync;
      // column counter saturates at IMG_W so overlong lines never wrap
      if (href && pix_col < COL_W'(IMG_W))
        col_q <= pix_col + 1'b1;
      if (vsync)
        row_q <= '0;
      else if (line_end && row_q < ROW_W'(IMG_H))
        row_q <= row_q + 1'b1;
    end
  end

  // R6: first pixel of a line is column 0, the next one column 1
  p_col_restart_r6: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (href && !hr_prev) |=> (!href || col_q == COL_W'(1)));
  // R6: row index is cleared by a vsync pulse
  p_row_clear_r6: assert property (@(posedge clk_pix) disable iff (!rst_n)
    vsync |=> (row_q == '0));
endmodule

// File: rtl/cap_arm.sv
module cap_arm
  import cap_pkg::*;
(
  input  logic clk_pix,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic vsync,
  input  logic vs_rise,
  input  logic line_end,
  output logic running,
  output logic frame_done
);
  arm_state_e state_q;
  logic       line_seen_q;

  assign running = (state_q == ARM_RUN) & cfg_done;

  always_ff @(posedge clk_pix) begin
    if (!rst_n) begin
      state_q     <= ARM_IDLE;
      line_seen_q <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= running & vs_rise & line_seen_q;
      if (!running || vs_rise)
        line_seen_q <= 1'b0;
      else if (line_end && !vsync)
        line_seen_q <= 1'b1;
      if (!cfg_done)
        state_q <= ARM_IDLE;
      else begin
        unique case (state_q)
          ARM_IDLE: state_q <= ARM_WAIT;
          ARM_WAIT: if (vsync) state_q <= ARM_RUN;
          default:  state_q <= ARM_RUN;
        endcase
      end
    end
  end

  // R3: entering the running state needs a sampled vsync pulse
  p_arm_on_vsync_r3: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (state_q == ARM_RUN && $past(state_q) != ARM_RUN) |-> $past(vsync));
  // R8: the frame pulse lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk_pix) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R9: dropping the done flag leaves the running state
  p_drop_done_r9: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !cfg_done |=> (state_q == ARM_IDLE));
endmodule

// File: rtl/cap_frame_writer.sv
module cap_frame_writer #(
  parameter int IMG_W     = 640,
  parameter int IMG_H     = 480,
  parameter int DEC_SHIFT = 1,
  localparam int BUF_W  = IMG_W >> DEC_SHIFT,
  localparam int BUF_H  = IMG_H >> DEC_SHIFT,
  localparam int DEPTH  = BUF_W * BUF_H,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int COL_W  = $clog2(IMG_W + 1),
  localparam int ROW_W  = $clog2(IMG_H + 1)
) (
  input  logic              clk_pix,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              vsync,
  input  logic              href,
  input  logic [7:0]        pix_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_done
);
  logic [COL_W-1:0]  pix_col;
  logic [ROW_W-1:0]  pix_row;
  logic              pix_ok, line_end, vs_rise, running;
  logic              on_grid, in_range, take;
  logic [ADDR_W-1:0] a_row, a_col, addr_next;

  cap_geom #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_geom (
    .clk_pix (clk_pix),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .href    (href),
    .pix_col (pix_col),
    .pix_row (pix_row),
    .pix_ok  (pix_ok),
    .line_end(line_end),
    .vs_rise (vs_rise)
  );

  cap_arm u_arm (
    .clk_pix   (clk_pix),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .vsync     (vsync),
    .vs_rise   (vs_rise),
    .line_end  (line_end),
    .running   (running),
    .frame_done(frame_done)
  );

  generate
    if (DEC_SHIFT == 0) begin : g_full
      assign on_grid = 1'b1;
    end else begin : g_dec
      assign on_grid = (pix_col[DEC_SHIFT-1:0] == '0) &&
                       (pix_row[DEC_SHIFT-1:0] == '0);
    end
  endgenerate

  assign in_range  = (pix_col < COL_W'(IMG_W)) && (pix_row < ROW_W'(IMG_H));
  assign take      = running & pix_ok & on_grid & in_range;
  assign a_row     = ADDR_W'(pix_row >> DEC_SHIFT);
  assign a_col     = ADDR_W'(pix_col >> DEC_SHIFT);
  assign addr_next = a_row * ADDR_W'(BUF_W) + a_col;

  always_ff @(posedge clk_pix) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= take;
      if (take) begin
        wr_addr <= addr_next;
        wr_data <= pix_data;
      end
    end
  end

  // R2: no write follows a cycle without the done flag
  p_idle_quiet_r2: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !cfg_done |=> !wr_valid);
  // R4: every write stems from an active pixel cycle
  p_write_from_pixel_r4: assert property (@(posedge clk_pix) disable iff (!rst_n)
    wr_valid |-> $past(href && !vsync));
  // R5: written byte is the byte sampled one clock earlier
  p_data_delay_r5: assert property (@(posedge clk_pix) disable iff (!rst_n)
    wr_valid |-> (wr_data == $past(pix_data)));
  // R7: addresses stay inside the packed buffer
  p_addr_bound_r7: assert property (@(posedge clk_pix) disable iff (!rst_n)
    wr_valid |-> (wr_addr < ADDR_W'(DEPTH)));
  // R8: frame pulse follows a vsync sample
  p_done_after_vs_r8: assert property (@(posedge clk_pix) disable iff (!rst_n)
    frame_done |-> $past(vsync));
endmodule

// File: tb/cap_frame_writer_bench.sv
module cap_frame_writer_bench;
  localparam int W = 8;
  localparam int H = 6;
  localparam int S = 1;
  localparam int BW = W >> S;
  localparam int AW = $clog2(BW * (H >> S));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_done = 1'b0;
  logic          vsync = 1'b0;
  logic          href = 1'b0;
  logic [7:0]    pix_data = 8'h00;
  logic          wr_valid, frame_done;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int checks = 0;
  int fails = 0;
  int wr_count = 0;
  int fd_count = 0;
  bit finished = 1'b0;
  string cur_req = "R4";

  // bench-side view of the frame position, derived from the requirements
  int  b_col = 0, b_row = 0;
  bit  hr_p = 0, vs_p = 0, ls = 0;
  int  ph = 0; // 0 idle, 1 waiting for vsync, 2 running

  always #4 clk = ~clk;

  cap_frame_writer #(.IMG_W(W), .IMG_H(H), .DEC_SHIFT(S)) u_cap_frame_writer (
    .clk_pix(clk), .rst_n(rst_n), .cfg_done(cfg_done), .vsync(vsync),
    .href(href), .pix_data(pix_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit vs, input bit hr, input logic [7:0] d);
    bit run, e_wr, e_fd, lend;
    int c, e_addr;
    run = (ph == 2) && cfg_done;
    e_wr = 0; e_addr = 0; c = 0;
    if (hr && !vs) begin
      c = hr_p ? b_col : 0;
      e_wr = run && (c % 2 == 0) && (b_row % 2 == 0) && (c < W) && (b_row < H);
      e_addr = (b_row / 2) * BW + c / 2;
    end
    if (hr) b_col = (hr_p ? b_col : 0) + 1;
    lend = hr_p && !hr;
    e_fd = run && vs && !vs_p && ls;
    if (!run || (vs && !vs_p)) ls = 0;
    else if (lend && !vs) ls = 1;
    if (vs) b_row = 0;
    else if (lend) b_row++;
    if (!cfg_done) ph = 0;
    else if (ph == 0) ph = 1;
    else if (ph == 1 && vs) ph = 2;
    hr_p = hr; vs_p = vs;
    vsync = vs; href = hr; pix_data = d;
    @(negedge clk);
    check(wr_valid == e_wr, cur_req, "wr_valid", int'(wr_valid), int'(e_wr));
    if (e_wr && wr_valid) begin
      check(int'(wr_addr) == e_addr, "R5", "wr_addr", int'(wr_addr), e_addr);
      check(wr_data == d, "R5", "wr_data", int'(wr_data), int'(d));
    end
    check(frame_done == e_fd, "R8", "frame_done", int'(frame_done), int'(e_fd));
    if (wr_valid) wr_count++;
    if (frame_done) fd_count++;
  endtask

  // R4: bytes on the bus during the vsync pulse, including a stray href, are ignored
  task automatic vs_pulse();
    string keep;
    keep = cur_req;
    cur_req = "R4";
    step(1, 0, 8'hA5);
    step(1, 1, 8'h5A);
    step(1, 0, 8'hC3);
    step(0, 0, 8'h3C);
    cur_req = keep;
  endtask

  task automatic frame(input int f, input bit with_vs, input int rows,
                       input int cols, input int drop_row);
    if (with_vs) vs_pulse();
    for (int r = 0; r < rows; r++) begin
      if (r == drop_row) cfg_done = 1'b0;
      step(0, 0, 8'hEE);
      step(0, 0, 8'h11);
      for (int c = 0; c < cols; c++)
        step(0, 1, 8'((f * 37 + r * 11 + c * 3) & 255));
      step(0, 0, 8'h77);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!wr_valid && !frame_done, "R1", "outputs in reset",
          int'({wr_valid, frame_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid && !frame_done, "R1", "outputs after release",
          int'({wr_valid, frame_done}), 0);

    cur_req = "R2";
    wr_count = 0;
    frame(1, 1, H, W, -1);
    vs_pulse();
    check(wr_count == 0, "R2", "writes while not configured", wr_count, 0);

    cfg_done = 1'b1;
    idle(3);
    cur_req = "R3";
    wr_count = 0;
    frame(2, 0, H, W, -1);
    check(wr_count == 0, "R3", "writes before first vsync", wr_count, 0);

    cur_req = "R5";
    wr_count = 0;
    frame(3, 1, H, W, -1);
    check(wr_count == (W / 2) * (H / 2), "R5", "writes in full frame",
          wr_count, (W / 2) * (H / 2));

    cur_req = "R6";
    wr_count = 0;
    frame(4, 1, 3, 4, -1);
    check(wr_count == 4, "R6", "writes in short frame", wr_count, 4);

    cur_req = "R7";
    wr_count = 0;
    frame(5, 1, H + 2, W + 3, -1);
    check(wr_count == (W / 2) * (H / 2), "R7", "writes in overlong frame",
          wr_count, (W / 2) * (H / 2));

    cur_req = "R8";
    fd_count = 0;
    frame(6, 1, 0, 0, -1);
    vs_pulse();
    check(fd_count == 1, "R8", "pulses around empty frame", fd_count, 1);

    cur_req = "R9";
    wr_count = 0;
    frame(7, 1, H, W, 2);
    check(wr_count == W / 2, "R9", "writes before done dropped", wr_count, W / 2);
    cfg_done = 1'b1;
    idle(3);
    wr_count = 0;
    frame(8, 0, H, W, -1);
    check(wr_count == 0, "R9", "writes before re-arm", wr_count, 0);
    frame(9, 1, H, W, -1);
    check(wr_count == (W / 2) * (H / 2), "R9", "writes after re-arm",
          wr_count, (W / 2) * (H / 2));
    fd_count = 0;
    vs_pulse();
    check(fd_count == 1, "R8", "pulse after re-armed frame", fd_count, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule